// File: doc/BRIEF.md
# Half-Duplex Collision Jam and Backoff Controller

This block sits beside a half-duplex Ethernet transmitter and takes over when the medium reports a collision. The transmitter tells it when an attempt is on the wire (`tx_active_i`) and when the preamble is still going out (`preamble_i`). A bit-time strobe paces all counting. When a collision is seen, the block drives a jam of all ones for a fixed number of bit times. If the preamble is still being sent, the jam starts only after the preamble ends.

Each collision is sorted by how far into the attempt it happened. The block keeps a count of the bit strobes sent since the attempt started. If that count is still below one slot time, the collision is early. The block then picks a random whole number of slot times, waits that long, and pulses `retry_o` so the transmitter can try again. The random range grows with each failed attempt, up to a cap. If the count has reached one slot time, the collision is late. The block then pulses `abort_o` and sets a late-collision flag, and no retry follows. A frame that collides too many times is also aborted, with its own excessive-retry flag.

Top module: `eth_coll_ctrl`

## Requirements
- R1: A collision is sampled with `tx_active_i` and `col_i` both high while the block is idle and `preamble_i` is low. In the next cycle `jam_en_o` and `jam_bit_o` go high. They stay high until the cycle after the JAM_BITS-th (default 32) bit strobe seen in the jam state, then fall.
- R2: If `preamble_i` is high when the collision is sampled, the jam is held back. `jam_en_o` rises the cycle after `preamble_i` is first sampled low.
- R3: The attempt bit count is the number of bit strobes sampled while `tx_active_i` has been continuously high. It returns to zero whenever `tx_active_i` is sampled low. A collision is early when this count is below SLOT_BITS (default 512) at the sampling edge, and late otherwise.
- R4: After an early collision, the jam is followed by a wait of exactly k×SLOT_BITS bit strobes. Then `retry_o` pulses for one cycle. Here n is the number of collisions in the current frame, and k lies in 0 to 2^min(n,BACKOFF_CAP)−1, with BACKOFF_CAP defaulting to 10. k is taken from a free-running pseudo-random register.
- R5: After a late collision, `abort_o` pulses for one cycle in the cycle that `jam_en_o` falls. `late_col_o` sets in the same cycle, and `retry_o` stays low. Late classification takes precedence over the retry limit.
- R6: When an early collision is the MAX_ATTEMPTS-th (default 16) of a frame, `abort_o` pulses and `excess_retry_o` sets as the jam ends. No backoff and no retry follow.
- R7: `late_col_o` and `excess_retry_o` hold their value until the clock edge that samples a rising `tx_active_i`, which clears them.
- R8: The collision count of a frame returns to zero when `tx_active_i` falls while no collision is being handled (a successful frame), and after any abort.
- R9: `col_i` has no effect while the block is deferring, jamming or backing off, nor while `tx_active_i` is low.
- R10: Under reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle strobe per bit time |
| col_i | input | 1 | Collision reported by the medium |
| preamble_i | input | 1 | Transmitter is sending the preamble |
| tx_active_i | input | 1 | A transmit attempt is in progress |
| jam_en_o | output | 1 | Jam overrides transmit data |
| jam_bit_o | output | 1 | Serial jam bit, all ones |
| retry_o | output | 1 | One-cycle pulse: backoff over, retry now |
| abort_o | output | 1 | One-cycle pulse: frame dropped |
| late_col_o | output | 1 | Late-collision error flag |
| excess_retry_o | output | 1 | Excessive-retry error flag |

## Verification
The end of a jam is where several functions meet in one cycle. On that strobe the block must choose among backoff, a late-collision abort and a retry-limit abort. The bench provokes the worst case: fifteen early collisions followed by a sixteenth that is late. That sixteenth collision is both the retry-limit attempt and a late one, and the late flag alone must set. Collisions placed exactly one strobe below and exactly at the slot boundary test the classification. Collisions held high through the jam and pulsed during backoff are judged against a per-cycle model that ignores them.

// File: rtl/eth_coll_pkg.sv
package eth_coll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DEFER   = 2'd1,
    ST_JAM     = 2'd2,
    ST_BACKOFF = 2'd3
  } coll_st_e;
endpackage

// File: rtl/eth_frame_bitcnt.sv
module eth_frame_bitcnt #(
  parameter int CNT_W     = 16,
  parameter int SLOT_BITS = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_active_i,
  input  logic bit_stb_i,
  output logic late_zone_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!tx_active_i) begin
      cnt_q <= '0;
    end else if (bit_stb_i && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign late_zone_o = (cnt_q >= CNT_W'(SLOT_BITS));

  AST_CNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_i |=> !late_zone_o); // R3
endmodule

// File: rtl/eth_bo_lfsr.sv
module eth_bo_lfsr #(
  parameter int          W     = 16,
  parameter int          OUT_W = 10,
  parameter logic [W-1:0] POLY = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else if (q[0]) q <= (q >> 1) ^ POLY;
    else q <= q >> 1;
  end

  assign rnd_o = q[OUT_W-1:0];

  AST_LFSR_ALIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0); // R4
endmodule

// File: rtl/eth_bo_timer.sv
module eth_bo_timer #(
  parameter int SLOT_BITS = 512,
  parameter int SLOTS_W   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SLOTS_W-1:0] slots_i,
  input  logic               bit_stb_i,
  output logic               done_o
);
  localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

  logic               active_q;
  logic [SLOTS_W-1:0] rem_q;
  logic [BIT_W-1:0]   bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      bit_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      rem_q    <= slots_i;
      bit_q    <= '0;
    end else if (active_q) begin
      if (rem_q == '0) begin
        active_q <= 1'b0;
      end else if (bit_stb_i) begin
        if (bit_q == BIT_W'(SLOT_BITS - 1)) begin
          bit_q <= '0;
          rem_q <= rem_q - 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign done_o = active_q && (rem_q == '0);

  AST_TMR_DONE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> !done_o); // R4
endmodule

// File: rtl/eth_coll_ctrl.sv
module eth_coll_ctrl
  import eth_coll_pkg::*;
#(
  parameter int SLOT_BITS    = 512,
  parameter int JAM_BITS     = 32,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10,
  parameter int CNT_W        = 16,
  parameter int LFSR_W       = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic col_i,
  input  logic preamble_i,
  input  logic tx_active_i,
  output logic jam_en_o,
  output logic jam_bit_o,
  output logic retry_o,
  output logic abort_o,
  output logic late_col_o,
  output logic excess_retry_o
);
  localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);
  localparam int JAM_W   = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
  localparam int SLOTS_W = BACKOFF_CAP;

  coll_st_e           st_q;
  logic [JAM_W-1:0]   jam_cnt_q;
  logic [ATT_W-1:0]   att_q;
  logic               col_late_q;
  logic               tx_q;
  logic               abort_q, retry_q, late_q, excess_q;

  logic               late_zone;
  logic               bo_done;
  logic [SLOTS_W-1:0] rnd;
  logic [ATT_W-1:0]   att_nxt;
  logic [ATT_W-1:0]   exp_w;
  logic [SLOTS_W-1:0] mask;
  logic               jam_last;
  logic               limit_hit;
  logic               bo_load;
  logic               tx_rise, tx_fall;

  eth_frame_bitcnt #(.CNT_W(CNT_W), .SLOT_BITS(SLOT_BITS)) u_bitcnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_active_i (tx_active_i),
    .bit_stb_i   (bit_stb_i),
    .late_zone_o (late_zone)
  );

  eth_bo_lfsr #(.W(LFSR_W), .OUT_W(SLOTS_W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnd_o  (rnd)
  );

  eth_bo_timer #(.SLOT_BITS(SLOT_BITS), .SLOTS_W(SLOTS_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (bo_load),
    .slots_i   (rnd & mask),
    .bit_stb_i (bit_stb_i),
    .done_o    (bo_done)
  );

  assign tx_rise   = tx_active_i && !tx_q;
  assign tx_fall   = !tx_active_i && tx_q;
  assign att_nxt   = att_q + 1'b1;
  assign exp_w     = (att_nxt > ATT_W'(BACKOFF_CAP)) ? ATT_W'(BACKOFF_CAP) : att_nxt;
  assign mask      = ~({SLOTS_W{1'b1}} << exp_w);
  assign jam_last  = (st_q == ST_JAM) && bit_stb_i && (jam_cnt_q == JAM_W'(JAM_BITS - 1));
  assign limit_hit = (att_nxt >= ATT_W'(MAX_ATTEMPTS));
  assign bo_load   = jam_last && !col_late_q && !limit_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      jam_cnt_q  <= '0;
      att_q      <= '0;
      col_late_q <= 1'b0;
      tx_q       <= 1'b0;
      abort_q    <= 1'b0;
      retry_q    <= 1'b0;
      late_q     <= 1'b0;
      excess_q   <= 1'b0;
    end else begin
      tx_q    <= tx_active_i;
      abort_q <= 1'b0;
      retry_q <= 1'b0;
      if (tx_rise) begin
        late_q   <= 1'b0;
        excess_q <= 1'b0;
      end
      unique case (st_q)
        ST_IDLE: begin
          if (tx_active_i && col_i) begin
            col_late_q <= late_zone;
            jam_cnt_q  <= '0;
            st_q       <= preamble_i ? ST_DEFER : ST_JAM;
          end else if (tx_fall) begin
            att_q <= '0;
          end
        end
        ST_DEFER: begin
          if (!preamble_i) st_q <= ST_JAM;
        end
        ST_JAM: begin
          if (jam_last) begin
            if (col_late_q) begin
              abort_q <= 1'b1;
              late_q  <= 1'b1;
              att_q   <= '0;
              st_q    <= ST_IDLE;
            end else if (limit_hit) begin
              abort_q  <= 1'b1;
              excess_q <= 1'b1;
              att_q    <= '0;
              st_q     <= ST_IDLE;
            end else begin
              att_q <= att_nxt;
              st_q  <= ST_BACKOFF;
            end
          end else if (bit_stb_i) begin
            jam_cnt_q <= jam_cnt_q + 1'b1;
          end
        end
        ST_BACKOFF: begin
          if (bo_done) begin
            retry_q <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign jam_en_o       = (st_q == ST_JAM);
  assign jam_bit_o      = (st_q == ST_JAM);
  assign retry_o        = retry_q;
  assign abort_o        = abort_q;
  assign late_col_o     = late_q;
  assign excess_retry_o = excess_q;

  AST_JAM_ENDS_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(jam_en_o) |-> $past(bit_stb_i)); // R1
  AST_JAM_AFTER_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jam_en_o) |-> !$past(preamble_i)); // R2
  AST_RETRY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !retry_o); // R4
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R5
  AST_ABORT_AT_JAM_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> $fell(jam_en_o)); // R5
  AST_LATE_NO_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_col_o |-> !retry_o); // R5
  AST_EXCESS_WITH_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(excess_retry_o) |-> abort_o); // R6
  AST_ONE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_o && retry_o)); // R6
endmodule

// File: tb/eth_coll_ctrl_test.sv
module eth_coll_ctrl_test;
  localparam int SLOT = 64;
  localparam int JAM  = 32;
  localparam int MAXA = 16;
  localparam int CAP  = 4;
  localparam int PRE  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic stb = 1'b0, col = 1'b0, pre = 1'b0, tx = 1'b0;
  logic jam_en, jam_bit, retry, abort_s, late, exc;

  eth_coll_ctrl #(.SLOT_BITS(SLOT), .JAM_BITS(JAM), .MAX_ATTEMPTS(MAXA),
                  .BACKOFF_CAP(CAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(stb), .col_i(col),
    .preamble_i(pre), .tx_active_i(tx), .jam_en_o(jam_en), .jam_bit_o(jam_bit),
    .retry_o(retry), .abort_o(abort_s), .late_col_o(late), .excess_retry_o(exc)
  );

  int vec = 0, bad = 0, cyc = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 defer, 2 jam, 3 backoff
  int m_st = 0, m_cnt = 0, m_jc = 0, m_att = 0, bo = 0, n_new = 0;
  bit m_islate = 0, m_abort = 0, m_late = 0, m_exc = 0, m_txq = 0;
  bit last_stb = 0, ret_ev = 0, rise = 0, fall = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_jc = 0; m_att = 0;
      m_islate = 0; m_abort = 0; m_late = 0; m_exc = 0; m_txq = 0; last_stb = 0;
    end else begin
      if (m_st == 3 && ret_ev) m_st = 0;
      rise = tx && !m_txq;
      fall = !tx && m_txq;
      m_abort = 0;
      last_stb = (m_st == 3) && stb;
      if (rise) begin m_late = 0; m_exc = 0; end
      case (m_st)
        0: begin
          if (tx && col) begin
            m_islate = (m_cnt >= SLOT);
            m_jc = 0;
            m_st = pre ? 1 : 2;
          end else if (fall) m_att = 0;
        end
        1: if (!pre) m_st = 2;
        2: if (stb) begin
          if (m_jc == JAM - 1) begin
            n_new = m_att + 1;
            if (m_islate) begin
              m_abort = 1; m_late = 1; m_att = 0; m_st = 0;
            end else if (n_new >= MAXA) begin
              m_abort = 1; m_exc = 1; m_att = 0; m_st = 0;
            end else begin
              m_att = n_new; m_st = 3;
            end
          end else m_jc++;
        end
        default: ;
      endcase
      if (!tx) m_cnt = 0;
      else if (stb) m_cnt++;
      m_txq = tx;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(jam_en === (m_st == 2), "R1 R2 jam_en", int'(jam_en), int'(m_st == 2));
      check(jam_bit === (m_st == 2), "R1 jam_bit", int'(jam_bit), int'(m_st == 2));
      check(abort_s === m_abort, "R5 R6 abort", int'(abort_s), int'(m_abort));
      check(late === m_late, "R5 R7 late_col", int'(late), int'(m_late));
      check(exc === m_exc, "R6 R7 excess", int'(exc), int'(m_exc));
      ret_ev = (m_st == 3) && retry;
      if (m_st == 3) begin
        if (retry) begin
          check(bo % SLOT == 0, "R4 whole slots", bo % SLOT, 0);
          check(bo / SLOT <= (1 << ((m_att < CAP) ? m_att : CAP)) - 1,
                "R4 backoff range", bo / SLOT, (1 << ((m_att < CAP) ? m_att : CAP)) - 1);
          bo = 0;
        end else bo += int'(last_stb);
      end else begin
        check(retry === 1'b0, "R4 R9 retry", int'(retry), 0);
      end
    end
  end

  task automatic drive_stb(int per);
    stb = (cyc % per == 0);
    cyc++;
  endtask

  task automatic attempt(int coll_at, int len, int per);
    int  n = 0;
    bit  seen = 0;
    tx = 1'b1;
    forever begin
      pre = (n < PRE);
      col = (coll_at >= 0) && (n >= coll_at);
      drive_stb(per);
      if (stb) n++;
      @(negedge clk);
      if (jam_en) seen = 1;
      if (seen && !jam_en) break;
      if (coll_at < 0 && n >= len) break;
    end
    tx = 1'b0; col = 1'b0; pre = 1'b0; stb = 1'b0;
  endtask

  task automatic wait_done(int per);
    int guard = 0;
    if (abort_s) return;
    forever begin
      col = cyc[1];  // R9: collisions while backing off with tx low
      drive_stb(per);
      @(negedge clk);
      guard++;
      if (retry || abort_s || guard > 20000) break;
    end
    col = 1'b0; stb = 1'b0;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      col = (i % 3 == 0);  // R9: ignored with tx low
      drive_stb(1);
      @(negedge clk);
    end
    col = 1'b0; stb = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; vec++;
    $display("FAIL watchdog R4 act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check({jam_en, jam_bit, retry, abort_s, late, exc} === 6'b0, "R10 reset outputs",
          int'({jam_en, jam_bit, retry, abort_s, late, exc}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    attempt(-1, 100, 1);                     // clean frame
    idle(5);
    attempt(30, 0, 1); wait_done(1);         // R1 R4 early collision
    attempt(-1, 80, 1); idle(5);             // R8 success
    attempt(5, 0, 1); wait_done(1);          // R2 collision in preamble
    attempt(-1, 40, 1); idle(5);
    attempt(100, 0, 1); wait_done(1);        // R5 late collision
    idle(40);                                // R7 flag holds
    attempt(-1, 40, 1); idle(5);             // R7 cleared on new frame
    attempt(SLOT - 1, 0, 1); wait_done(1);   // R3 last early count
    attempt(-1, 30, 1); idle(3);
    attempt(SLOT, 0, 1); wait_done(1);       // R3 first late count
    idle(5);
    attempt(40, 0, 3); wait_done(3);         // R1 R4 sparse strobes
    attempt(-1, 50, 2); idle(5);
    for (int i = 0; i < 3; i++) begin        // R8 count clears after success
      attempt(20, 0, 1); wait_done(1);
    end
    attempt(-1, 30, 1); idle(3);
    attempt(20, 0, 1); wait_done(1);
    attempt(-1, 30, 1); idle(3);
    for (int i = 0; i < MAXA; i++) begin     // R6 retry limit
      attempt(20, 0, 1); wait_done(1);
    end
    idle(20);
    attempt(-1, 20, 1); idle(3);             // R7 excess cleared
    for (int i = 0; i < MAXA - 1; i++) begin // R5 late wins at the limit
      attempt(25, 0, 1); wait_done(1);
    end
    attempt(SLOT + 10, 0, 1); wait_done(1);
    idle(10);
    check(late === 1'b1 && exc === 1'b0, "R5 late precedence",
          int'({late, exc}), 2);
    summary();
    $finish;
  end
endmodule